// File: doc/BRIEF.md
# Status-Stage ACK Gating Controller

This block sits on the endpoint-zero path of a USB device controller. It decides the handshake for the status IN stage of a control transfer. For most requests that stage is acknowledged at once. After a SET_CONFIGURATION or SET_INTERFACE request, firmware can instead hold the host at NAK until it has finished reconfiguring. Firmware then releases exactly one ACK.

Two bits in a small control register govern this: a hold-mode bit and a release bit. Both are write-one-to-set. The block watches decoded setup packets (strobe plus bRequest code) and the status-IN token strobe. One clock after each status-IN strobe it presents a registered handshake pair (valid, ack). ack=1 means ACK and ack=0 means NAK.

Top module: `status_ack_gate`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x7E. Bit 0 is the hold-mode bit and reads 0. Bits 6:1 always read 1. Bit 7 is the release bit and reads 0.
- R2: A write sets the hold-mode bit when `cfg_wr_data[0]`=1 and sets the release bit when `cfg_wr_data[7]`=1. Writing 0 clears neither bit. The new value reads back from the cycle after the write.
- R3: A setup strobe with bRequest 9 or 11 marks a configuration request as pending.
- R4: A status-IN strobe with no configuration request pending is answered with ACK.
- R5: With the hold-mode bit at 0, a pending configuration request gets ACK on its status IN. The pending mark then clears.
- R6: With the hold-mode bit at 1 and the release bit at 0, every status IN of a pending request gets NAK, and the request stays pending.
- R7: With both bits at 1, the next status IN of a pending request gets ACK. That ACK clears the release bit and the pending mark, so each release grants one ACK.
- R8: A setup strobe with any other bRequest clears the pending mark.
- R9: `bus_reset` clears the pending mark, the release bit and the hold-mode bit.
- R10: `hs_valid` is 1 exactly in the cycle after a status-IN strobe and 0 otherwise. `hs_ack` is 0 whenever `hs_valid` is 0.
- R11: A write that sets the release bit in the same cycle that a granted ACK consumes it leaves the release bit at 1.
- R12: While the hold-mode bit is 0, the release bit is never consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | Synchronous USB bus reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control register read image |
| setup_valid | input | 1 | Setup packet decoded strobe |
| setup_req | input | 8 | bRequest of the decoded setup packet |
| status_in_req | input | 1 | Status-stage IN token strobe |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |

## Verification
A status-IN strobe applied at one clock edge produces its handshake at the next edge. The bench therefore reads `hs_valid` and `hs_ack` on the falling edge one cycle after the strobe. A register write or setup strobe changes state at the edge it is sampled on, and its effect is visible in `cfg_rd_data` and in the next decision from the following falling edge. A behavioural model updates on each rising edge from the same inputs, and its outputs are compared with the design on every falling edge. Directed checks sample at those same falling edges.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam logic [7:0] REQ_SET_CONFIG = 8'd9;
  localparam logic [7:0] REQ_SET_IFACE  = 8'd11;

  function automatic logic is_cfg_req(input logic [7:0] breq);
    return (breq == REQ_SET_CONFIG) || (breq == REQ_SET_IFACE);
  endfunction

  // ACK unless a pending request is held and not released
  function automatic logic ack_rule(input logic pend, input logic mode, input logic rel);
    return !pend || !mode || rel;
  endfunction

  // release bit is spent only on a held request being granted
  function automatic logic spend_rule(input logic pend, input logic mode, input logic rel);
    return pend && mode && rel;
  endfunction
endpackage

// File: rtl/sag_ctrl_reg.sv
module sag_ctrl_reg #(
  parameter int REG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int MODE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             grant_take,
  output logic             mode_q,
  output logic             en_q,
  output logic [REG_W-1:0] rd_data
);
  logic set_mode, set_en;
  assign set_mode = wr_en && wr_data[MODE_BIT];
  assign set_en   = wr_en && wr_data[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (bus_reset) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_q | set_mode;
      en_q   <= (en_q & ~grant_take) | set_en;
    end
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i == EN_BIT) begin : g_en
      assign rd_data[i] = en_q;
    end else if (i == MODE_BIT) begin : g_mode
      assign rd_data[i] = mode_q;
    end else if (i < EN_BIT) begin : g_one
      assign rd_data[i] = 1'b1;
    end else begin : g_rsv
      assign rd_data[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sag_req_track.sv
module sag_req_track #(
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             setup_valid,
  input  logic [REQ_W-1:0] setup_req,
  input  logic             status_in_req,
  input  logic             ack_now,
  output logic             pend_q
);
  import sag_pkg::*;

  logic stage_done;
  assign stage_done = status_in_req && ack_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= 1'b0;
    else if (bus_reset)     pend_q <= 1'b0;
    else if (setup_valid)   pend_q <= is_cfg_req(8'(setup_req));
    else if (stage_done)    pend_q <= 1'b0;
  end
endmodule

// File: rtl/sag_hs_decide.sv
module sag_hs_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic status_in_req,
  input  logic pend_q,
  input  logic mode_q,
  input  logic en_q,
  output logic ack_now,
  output logic grant_take,
  output logic hs_valid,
  output logic hs_ack
);
  import sag_pkg::*;

  assign ack_now    = ack_rule(pend_q, mode_q, en_q);
  assign grant_take = status_in_req && spend_rule(pend_q, mode_q, en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
    end else if (bus_reset) begin
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
    end else begin
      hs_valid <= status_in_req;
      hs_ack   <= status_in_req && ack_now;
    end
  end
endmodule

// File: rtl/status_ack_gate.sv
module status_ack_gate #(
  parameter int REG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int MODE_BIT = 0,
  parameter int REQ_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             setup_valid,
  input  logic [REQ_W-1:0] setup_req,
  input  logic             status_in_req,
  output logic             hs_valid,
  output logic             hs_ack
);
  // internal events, named for the checker
  logic pend_q, mode_q, en_q, ack_now, grant_take;

  sag_ctrl_reg #(.REG_W(REG_W), .EN_BIT(EN_BIT), .MODE_BIT(MODE_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .grant_take(grant_take),
    .mode_q(mode_q), .en_q(en_q), .rd_data(cfg_rd_data)
  );

  sag_req_track #(.REQ_W(REQ_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .setup_valid(setup_valid), .setup_req(setup_req),
    .status_in_req(status_in_req), .ack_now(ack_now), .pend_q(pend_q)
  );

  sag_hs_decide u_hs (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .status_in_req(status_in_req), .pend_q(pend_q), .mode_q(mode_q), .en_q(en_q),
    .ack_now(ack_now), .grant_take(grant_take), .hs_valid(hs_valid), .hs_ack(hs_ack)
  );
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int REG_W  = 8,
  parameter int EN_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_reset,
  input logic             status_in_req,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             pend_q,
  input logic             mode_q,
  input logic             en_q,
  input logic             grant_take,
  input logic             hs_valid,
  input logic             hs_ack
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    status_in_req |=> hs_valid);
  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    !status_in_req |=> (!hs_valid && !hs_ack));
  // R4
  ungated_ack_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (status_in_req && !pend_q) |=> hs_ack);
  // R6
  hold_nak_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (status_in_req && pend_q && mode_q && !en_q) |=> (!hs_ack && pend_q));
  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (grant_take && !(wr_en && wr_data[EN_BIT])) |=> (!en_q && hs_ack));
  // R2
  sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    mode_q |=> mode_q);
  // R12
  keep_release_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (en_q && !mode_q) |=> en_q);
endmodule

bind status_ack_gate sag_chk #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .status_in_req(status_in_req),
  .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .pend_q(pend_q), .mode_q(mode_q),
  .en_q(en_q), .grant_take(grant_take), .hs_valid(hs_valid), .hs_ack(hs_ack)
);

// File: tb/status_ack_gate_test.sv
module status_ack_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       setup_valid = 1'b0;
  logic [7:0] setup_req = 8'h00;
  logic       status_in_req = 1'b0;
  logic       hs_valid, hs_ack;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // reference model state
  bit m_mode = 0, m_rel = 0, m_pend = 0, e_v = 0, e_a = 0;

  always #10 clk = ~clk;  // 50 MHz

  status_ack_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .setup_valid(setup_valid), .setup_req(setup_req), .status_in_req(status_in_req),
    .hs_valid(hs_valid), .hs_ack(hs_ack)
  );

  always @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      m_mode = 0; m_rel = 0; m_pend = 0; e_v = 0; e_a = 0;
    end else begin
      bit grant_ack;
      grant_ack = (m_pend == 0) || (m_mode == 0) || (m_rel == 1);
      e_v = status_in_req;
      e_a = status_in_req && grant_ack;
      if (status_in_req && m_pend && m_mode && m_rel) m_rel = 0;
      if (status_in_req && grant_ack) m_pend = 0;
      if (setup_valid) m_pend = (setup_req == 8'd9) || (setup_req == 8'd11);
      if (cfg_wr_en) begin
        if (cfg_wr_data[0]) m_mode = 1;
        if (cfg_wr_data[7]) m_rel = 1;
      end
    end
  end

  function automatic logic [7:0] model_rd();
    return {m_rel, 6'b111111, m_mode};
  endfunction

  // every-cycle comparison (R10 for the handshake timing)
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (hs_valid !== e_v || hs_ack !== e_a || cfg_rd_data !== model_rd()) begin
        errors++;
        $display("FAIL R10 cycle compare: got v=%0b a=%0b rd=%h expected v=%0b a=%0b rd=%h",
                 hs_valid, hs_ack, cfg_rd_data, e_v, e_a, model_rd());
      end
    end
  end

  task automatic check_rd(input string tag, input logic [7:0] exp);
    checks++;
    if (cfg_rd_data !== exp) begin
      errors++;
      $display("FAIL %s readback: got %h expected %h", tag, cfg_rd_data, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0; cfg_wr_data = 8'h00;
  endtask

  task automatic setup(input logic [7:0] b);
    @(negedge clk); setup_valid = 1'b1; setup_req = b;
    @(negedge clk); setup_valid = 1'b0; setup_req = 8'h00;
  endtask

  task automatic bus_rst();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  // strobe status IN, then sample handshake one cycle later
  task automatic status(input string tag, input logic exp_ack, input logic [7:0] wd = 8'h00,
                        input bit do_wr = 0);
    @(negedge clk); status_in_req = 1'b1; cfg_wr_en = do_wr; cfg_wr_data = wd;
    @(negedge clk); status_in_req = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 8'h00;
    checks++;
    if (hs_valid !== 1'b1 || hs_ack !== exp_ack) begin
      errors++;
      $display("FAIL %s handshake: got v=%0b a=%0b expected v=1 a=%0b", tag, hs_valid, hs_ack, exp_ack);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    check_rd("R1", 8'h7E);

    status("R4 no pending", 1'b1);

    setup(8'd9);
    status("R5 auto ack", 1'b1);
    status("R5 pending cleared", 1'b1);

    wr(8'h01);  check_rd("R2 set mode", 8'h7F);
    wr(8'h00);  check_rd("R2 zero write", 8'h7F);

    setup(8'd11);
    status("R3 set_interface pending", 1'b0);
    status("R6 still held", 1'b0);

    wr(8'h80);  check_rd("R2 set release", 8'hFF);
    status("R7 released ack", 1'b1);
    check_rd("R7 release spent", 8'h7F);
    status("R7 pending cleared", 1'b1);
    setup(8'd9);
    status("R7 one shot", 1'b0);

    setup(8'd6);
    status("R8 other request clears", 1'b1);
    setup(8'd9); setup(8'd0);
    status("R8 clear after set_config", 1'b1);

    setup(8'd9); wr(8'h80);
    status("R11 grant with rewrite", 1'b1, 8'h80, 1);
    check_rd("R11 release kept", 8'hFF);

    setup(8'd9);
    bus_rst();
    check_rd("R9 bits cleared", 8'h7E);
    wr(8'h01);
    status("R9 pending cleared", 1'b1);

    bus_rst();
    wr(8'h80);  check_rd("R12 release in auto mode", 8'hFE);
    setup(8'd11);
    status("R12 auto ack", 1'b1);
    check_rd("R12 release not spent", 8'hFE);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule